// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block turns a single memory access request into the pin sequence a multiplexed-address dynamic RAM expects. A request is a full address with read and write flags, and it is offered by raising an enable input while the sequencer is idle. The sequencer then captures the request. It places the upper half of the address on a half-width address bus and raises the row strobe one cycle later. Next it places the lower half on the same bus and raises the column strobe one cycle later. The write-enable pin is set according to the captured operation during the column phase. The sequencer then drops every strobe and returns to idle.

A request with both flags set stops after the row phase and has no column phase. Each strobe trails its address by exactly one clock, so the address has settled for a full cycle before the strobe edge that latches it. The enable input is ignored while a sequence is under way. A new request is taken in the first idle cycle, so a requester that holds enable high gets sequences that follow each other without a gap.

Top module: `dram_addr_seq`

## Requirements
- R1: While the active-low reset rst_n is sampled low at a clock edge, the sequencer goes idle and, from the following cycle on, drives addr_o=0, ras_o=0, cas_o=0 and we_o=0. This holds even when reset arrives in the middle of a sequence.
- R2: While idle with en_i low, all outputs stay at 0, whatever addr_i, rd_i and wr_i do.
- R3: At the clock edge where en_i=1 is accepted, addr_i[15:8] is stored as the row and addr_i[7:0] as the column, and rd_i and wr_i are stored with them. Later changes on those inputs do not alter the running sequence.
- R4: In the first cycle after acceptance, addr_o shows the row with ras_o=0. In the second cycle, addr_o still shows the row and ras_o=1.
- R5: For a request that is not row-only, the third cycle shows the column with ras_o=1 and cas_o=0. The fourth cycle shows the column with ras_o=1 and cas_o=1.
- R6: we_o=1 in the third and fourth cycles only for a write (rd=0, wr=1). For a read (rd=1, wr=0) and for a request with neither flag set, we_o stays 0.
- R7: A request with rd=1 and wr=1 ends after the second cycle. The third cycle is idle with all outputs 0, and cas_o and we_o are never raised.
- R8: The cycle after the last strobe cycle is idle with all outputs 0. An en_i seen in that cycle is accepted, so the next row appears in the cycle that follows.
- R9: en_i and the request inputs are ignored in every non-idle cycle, including the last strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Request valid; taken only when idle |
| addr_i | input | 16 | Request address: row in upper half, column in lower half |
| rd_i | input | 1 | Read flag of the request |
| wr_i | input | 1 | Write flag of the request |
| addr_o | output | 8 | Multiplexed row/column address to the memory |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| we_o | output | 1 | Write enable, active high |

## Verification
Two functions can land on the same clock edge: the end of one sequence and the acceptance of the next request. Enable is held high through whole sequences while the request inputs carry decoy values. The decoys present in the final strobe cycle must be ignored, and the real request presented in the idle cycle must be taken. A scoreboard fixes the expected output of every cycle by its cycle number. A stray capture, a lost request or an idle cycle that comes too early or too late shows up as a mismatch in a specific cycle. The same overlap is provoked after a row-only request, whose sequence is two cycles shorter.

// File: rtl/dram_seq_pkg.sv
// Package dram_seq_pkg
// Holds the sequencer state encoding and the operation class of a captured request.
// Assumes the sequencer visits the states in declaration order, apart from the early
// exit taken by a row-only request.
package dram_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_ROW_SET = 3'd1,
        SQ_ROW_STB = 3'd2,
        SQ_COL_SET = 3'd3,
        SQ_COL_STB = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        OPK_READ     = 2'd0,
        OPK_WRITE    = 2'd1,
        OPK_ROW_ONLY = 2'd2
    } op_kind_t;

    // Classify the read/write flags; neither set is handled as a read.
    function automatic op_kind_t classify_op(input logic rd, input logic wr);
        op_kind_t k;
        if (rd && wr)
            k = OPK_ROW_ONLY;
        else if (wr)
            k = OPK_WRITE;
        else
            k = OPK_READ;
        return k;
    endfunction

endpackage

// File: rtl/dram_req_latch.sv
// Module dram_req_latch
// Holds the row half, the column half and the operation class of the request
// accepted by the sequencer. It loads only on the load pulse and keeps its value
// otherwise. Assumes the load pulse comes only from the idle state.
module dram_req_latch
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rd_in,
    input  logic              wr_in,
    output logic [HALF_W-1:0] row_q,
    output logic [HALF_W-1:0] col_q,
    output op_kind_t          op_q
);

    // Capture the request on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            op_q  <= OPK_READ;
        end else if (load) begin
            row_q <= addr_in[ADDR_W-1:HALF_W];
            col_q <= addr_in[HALF_W-1:0];
            op_q  <= classify_op(rd_in, wr_in);
        end
    end

endmodule

// File: rtl/dram_seq_fsm.sv
// Module dram_seq_fsm
// Steps through the address and strobe phases of one access. It issues a load
// pulse when a request is accepted in idle and skips the column phases for a
// row-only request. Assumes op_kind is valid from the cycle after the load pulse.
module dram_seq_fsm
    import dram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  op_kind_t   op_kind,
    output logic       load,
    output seq_state_t state
);

    seq_state_t nxt;

    // A request is taken only while idle.
    assign load = (state == SQ_IDLE) && start;

    // Select the next phase.
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:    nxt = start ? SQ_ROW_SET : SQ_IDLE;
            SQ_ROW_SET: nxt = SQ_ROW_STB;
            SQ_ROW_STB: nxt = (op_kind == OPK_ROW_ONLY) ? SQ_IDLE : SQ_COL_SET;
            SQ_COL_SET: nxt = SQ_COL_STB;
            SQ_COL_STB: nxt = SQ_IDLE;
            default:    nxt = SQ_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SQ_IDLE;
        else
            state <= nxt;
    end

endmodule

// File: rtl/dram_pin_drive.sv
// Module dram_pin_drive
// Maps the sequencer phase and the captured request onto the memory pins.
// Each output is assigned in every phase, so no storage is inferred. Assumes
// the state is a registered value.
module dram_pin_drive
    import dram_seq_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  seq_state_t        state,
    input  logic [HALF_W-1:0] row_q,
    input  logic [HALF_W-1:0] col_q,
    input  op_kind_t          op_q,
    output logic [HALF_W-1:0] addr_o,
    output logic              ras_o,
    output logic              cas_o,
    output logic              we_o
);

    logic col_phase;

    // True in both column cycles.
    assign col_phase = (state == SQ_COL_SET) || (state == SQ_COL_STB);

    // Drive the address bus and the strobes for the current phase.
    always_comb begin
        addr_o = '0;
        ras_o  = 1'b0;
        cas_o  = 1'b0;
        we_o   = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                addr_o = '0;
            end
            SQ_ROW_SET: begin
                addr_o = row_q;
            end
            SQ_ROW_STB: begin
                addr_o = row_q;
                ras_o  = 1'b1;
            end
            SQ_COL_SET: begin
                addr_o = col_q;
                ras_o  = 1'b1;
            end
            SQ_COL_STB: begin
                addr_o = col_q;
                ras_o  = 1'b1;
                cas_o  = 1'b1;
            end
            default: begin
                addr_o = '0;
            end
        endcase
        we_o = col_phase && (op_q == OPK_WRITE);
    end

endmodule

// File: rtl/dram_addr_seq.sv
// Module dram_addr_seq
// Top of the row/column address sequencer. It accepts one request while idle,
// then drives the row, the row strobe, the column, the column strobe and the
// write enable in turn. Assumes inputs are synchronous to clk.
module dram_addr_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output logic [HALF_W-1:0] addr_o,
    output logic              ras_o,
    output logic              cas_o,
    output logic              we_o
);

    logic              load;
    seq_state_t        state;
    logic [HALF_W-1:0] row_q;
    logic [HALF_W-1:0] col_q;
    op_kind_t          op_q;

    dram_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (en_i),
        .op_kind (op_q),
        .load    (load),
        .state   (state)
    );

    dram_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .addr_in (addr_i),
        .rd_in   (rd_i),
        .wr_in   (wr_i),
        .row_q   (row_q),
        .col_q   (col_q),
        .op_q    (op_q)
    );

    dram_pin_drive #(.HALF_W(HALF_W)) u_drive (
        .state  (state),
        .row_q  (row_q),
        .col_q  (col_q),
        .op_q   (op_q),
        .addr_o (addr_o),
        .ras_o  (ras_o),
        .cas_o  (cas_o),
        .we_o   (we_o)
    );

endmodule

// File: rtl/dram_seq_chk.sv
// Module dram_seq_chk
// Watches the memory-side pins of the sequencer and checks the phase ordering
// between address, strobes and write enable. Bound into dram_addr_seq below.
module dram_seq_chk #(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HALF_W-1:0] addr_o,
    input logic              ras_o,
    input logic              cas_o,
    input logic              we_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ras_o && !cas_o && !we_o && addr_o == '0));

    // R4
    ras_after_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_o) |-> ($stable(addr_o) && !cas_o && !we_o));

    // R5
    cas_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_o) |-> ($stable(addr_o) && ras_o && $past(ras_o)));

    // R5
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_o |-> ras_o);

    // R6
    we_in_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> ras_o);

    // R6
    we_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_o) |-> $stable(we_o));

    // R8
    idle_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_o |=> (!cas_o && !ras_o && !we_o && addr_o == '0));

endmodule

bind dram_addr_seq dram_seq_chk #(.HALF_W(HALF_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_o (addr_o),
    .ras_o  (ras_o),
    .cas_o  (cas_o),
    .we_o   (we_o)
);

// File: tb/test_dram_addr_seq.sv
// Scoreboard bench: the driver pushes the expected pin values for each future
// cycle; a monitor compares them in the cycle they apply to.
module test_dram_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  addr_o;
    logic        ras_o, cas_o, we_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] a;
        logic       ras;
        logic       cas;
        logic       we;
        string      tag;
    } exp_t;

    exp_t sb[$];

    dram_addr_seq i_dram_addr_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .addr_i(addr_i),
        .rd_i(rd_i), .wr_i(wr_i), .addr_o(addr_o), .ras_o(ras_o),
        .cas_o(cas_o), .we_o(we_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [7:0] a, input logic r,
                         input logic c, input logic w);
        n_chk++;
        if (addr_o !== a || ras_o !== r || cas_o !== c || we_o !== w) begin
            n_fail++;
            $display("FAIL %s cycle %0d: addr=%h ras=%b cas=%b we=%b expected addr=%h ras=%b cas=%b we=%b",
                     tag, cyc, addr_o, ras_o, cas_o, we_o, a, r, c, w);
        end
    endtask

    task automatic push(input int at, input logic [7:0] a, input logic r,
                        input logic c, input logic w, input string tag);
        exp_t e;
        e.at = at; e.a = a; e.ras = r; e.cas = c; e.we = w; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare expectations due in the current cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.at < cyc) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s cycle %0d: expectation missed, actual cycle %0d", e.tag, e.at, cyc);
                end else begin
                    check(e.tag, e.a, e.ras, e.cas, e.we);
                end
            end
        end
    end

    // Driver: offer one request at this negedge and queue its expected pins.
    // hold keeps en_i high with decoy inputs while busy (R9).
    task automatic issue(input logic [15:0] a, input logic rd, input logic wr,
                         input bit hold);
        int  c0;
        int  len;
        bit  both;
        bit  wrt;
        @(negedge clk);
        en_i = 1'b1; addr_i = a; rd_i = rd; wr_i = wr;
        c0   = cyc;
        both = rd && wr;
        wrt  = wr && !rd;
        len  = both ? 2 : 4;
        push(c0 + 1, a[15:8], 1'b0, 1'b0, 1'b0, "R3 R4 row set");
        push(c0 + 2, a[15:8], 1'b1, 1'b0, 1'b0, "R4 row strobe");
        if (both) begin
            push(c0 + 3, 8'h00, 1'b0, 1'b0, 1'b0, "R7 row-only end");
        end else begin
            push(c0 + 3, a[7:0], 1'b1, 1'b0, wrt, "R3 R5 R6 col set");
            push(c0 + 4, a[7:0], 1'b1, 1'b1, wrt, "R5 R6 col strobe");
            push(c0 + 5, 8'h00, 1'b0, 1'b0, 1'b0, "R8 idle after sequence");
        end
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            en_i   = hold;
            addr_i = ~a ^ 16'(k * 16'h1357);
            rd_i   = ~rd;
            wr_i   = ~wr;
        end
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R2: idle with en low, inputs moving
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_i = 16'hFFFF - 16'(k * 16'h1111);
            rd_i = k[0]; wr_i = k[1];
            push(cyc + 1, 8'h00, 1'b0, 1'b0, 1'b0, "R2 idle");
        end
        drain();

        // Single requests: write, read, neither, row-only
        issue(16'hA55A, 1'b0, 1'b1, 1'b0);
        drain();
        issue(16'h1234, 1'b1, 1'b0, 1'b0);
        drain();
        issue(16'h00FF, 1'b0, 1'b0, 1'b0);
        drain();
        issue(16'hBEEF, 1'b1, 1'b1, 1'b0);
        drain();

        // R8 R9: back-to-back with en held high and decoys while busy
        issue(16'h8001, 1'b0, 1'b1, 1'b1);
        issue(16'h7F80, 1'b1, 1'b0, 1'b1);
        issue(16'hC3C3, 1'b1, 1'b1, 1'b1);
        issue(16'h5AA5, 1'b0, 1'b1, 1'b0);
        drain();

        // R1: reset in the middle of a sequence
        @(negedge clk);
        en_i = 1'b1; addr_i = 16'h6699; rd_i = 1'b0; wr_i = 1'b1;
        @(negedge clk);
        en_i = 1'b0;
        check("R4 pre-reset row", 8'h66, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-sequence reset", 8'h00, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 8'h00, 1'b0, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule